// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM. The read path is pipelined and the write path is delayed. A read command returns its word two clock edges after its address is taken. A write command takes its data two edges after its address. Because both directions share that two-edge offset, read and write commands can alternate on every clock with no idle cycle to turn the bus around.

Each command cycle loads a new address, or continues the current operation as a four-beat burst whose address low bits come from a separate burst sequencer. Writes pass through a one-entry commit buffer before they reach the array. A read that hits the buffered word sees that data, lane by lane.

The full-size part is instantiated with `ADDR_W = 16` and `DATA_W = 32`, which gives 65,536 words of 32 bits. The default address width is kept small so that elaboration stays light. The data bus is split into an input port, an output port and an output-drive indication.

Top module: `sram_ntd_pipe`

## Requirements
- R1: A read command loaded at edge k drives its word on `dq_out` from edge k+2 onward, with `dq_oe` high while `oe_n` is low.
- R2: A write command loaded at edge k stores `dq_in` as sampled at edge k+2. `dq_oe` is low in the cycle after a write's data edge.
- R3: `be_n[i]` is active low and gates data bits 8i+7 to 8i. It is sampled in the same cycle as the command's address, and lanes whose bit is high keep their old contents.
- R4: A read issued right behind a write to the same word, including one whose data is still in the commit buffer, returns the new bytes merged over the old ones.
- R5: When `adv_ld_n` is high, the previous read or write continues at the next burst address and `rd_wr_n` is ignored.
- R6: The burst steps only the two address low bits, starting from the loaded value b, and wraps after four beats. With `lin_burst` high, beat n uses (b+n) mod 4. With `lin_burst` low, beat n uses b XOR n.
- R7: A load cycle selects the device only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination is a deselect: nothing is written, and `dq_oe` is low two edges later.
- R8: A continue cycle that follows a deselect is a dummy: it drives no data and writes nothing.
- R9: While `cke_n` is high, rising edges are ignored. The pipeline, the burst position, the output and the array all keep their state.
- R10: `oe_n` acts on `dq_oe` combinationally, in the same cycle and without waiting for a clock edge.
- R11: While `zz` is high, a command cycle is treated as a deselect, so no new read or write is accepted.
- R12: After reset, `dq_oe` is low and no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| zz | input | 1 | Snooze request; new commands are refused |
| adv_ld_n | input | 1 | Low: load a new command; high: continue the burst |
| rd_wr_n | input | 1 | Command direction on load: 1 read, 0 write |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| be_n | input | DATA_W/8 | Byte lane write enables, active low |
| lin_burst | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq_in | input | DATA_W | Write data, sampled two edges after the address |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | High when the outputs would be driven |

## Verification
The output assertions look back up to four sampled edges. They take the condition that `cke_n` stayed low across that window as a precondition, because a frozen edge stretches the pipeline. They also assume that the control inputs carry known values on every enabled edge after reset. The bench changes every input only at falling edges and keeps all controls at defined levels, including the chip selects on continue cycles. During its freeze test it holds the clock enable high for whole cycles only.

// File: rtl/sram_ntd_pkg.sv
`timescale 1ns/1ps
package sram_ntd_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;
endpackage

// File: rtl/sram_burst_seq.sv
`timescale 1ns/1ps
module sram_burst_seq
    import sram_ntd_pkg::*;
#(
    parameter int CW = BURST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] base_lo,
    input  logic          linear,
    output logic [CW-1:0] nxt_lo
);
    typedef struct packed {
        logic [CW-1:0] base;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = seq_q.cnt + CW'(1);
        nxt_lo  = linear ? (seq_q.base + cnt_inc) : (seq_q.base ^ cnt_inc);
        seq_d   = seq_q;
        if (en) begin
            if (load) begin
                seq_d.base = base_lo;
                seq_d.cnt  = '0;
            end else if (step) begin
                seq_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/sram_store.sv
`timescale 1ns/1ps
module sram_store
    import sram_ntd_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [DW/LANE_W-1:0] wlane,
    input  logic [AW-1:0]        raddr,
    output logic [DW-1:0]        rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NB    = DW / LANE_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NB; i++) begin
                if (wlane[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sram_ntd_pipe.sv
`timescale 1ns/1ps
module sram_ntd_pipe
    import sram_ntd_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     zz,
    input  logic                     adv_ld_n,
    input  logic                     rd_wr_n,
    input  logic                     cs0_n,
    input  logic                     cs1,
    input  logic                     cs2_n,
    input  logic [DATA_W/LANE_W-1:0] be_n,
    input  logic                     lin_burst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     oe_n,
    input  logic [DATA_W-1:0]        dq_in,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe
);
    localparam int NB = DATA_W / LANE_W;
    localparam int HW = ADDR_W - BURST_W;

    typedef struct packed {
        op_e               s1_op;
        logic [ADDR_W-1:0] s1_addr;
        logic [NB-1:0]     s1_lane;
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic [NB-1:0]     s2_lane;
        logic              wb_vld;
        logic [ADDR_W-1:0] wb_addr;
        logic [NB-1:0]     wb_lane;
        logic [DATA_W-1:0] wb_data;
        logic [DATA_W-1:0] dout;
        logic              drive;
    } pipe_t;

    pipe_t               pipe_d, pipe_q;
    logic                en, sel_ok, ld_go, step_go;
    logic [BURST_W-1:0]  nxt_lo;
    logic [DATA_W-1:0]   arr_rd, rd_merged;

    assign en     = !cke_n;
    assign sel_ok = !cs0_n && cs1 && !cs2_n && !zz;

    sram_burst_seq #(.CW(BURST_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (ld_go),
        .step    (step_go),
        .base_lo (addr[BURST_W-1:0]),
        .linear  (lin_burst),
        .nxt_lo  (nxt_lo)
    );

    sram_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk   (clk),
        .we    (en && pipe_q.wb_vld),
        .waddr (pipe_q.wb_addr),
        .wdata (pipe_q.wb_data),
        .wlane (pipe_q.wb_lane),
        .raddr (pipe_q.s2_addr),
        .rdata (arr_rd)
    );

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            rd_merged[i*LANE_W +: LANE_W] =
                (pipe_q.wb_vld && pipe_q.wb_addr == pipe_q.s2_addr && pipe_q.wb_lane[i])
                ? pipe_q.wb_data[i*LANE_W +: LANE_W] : arr_rd[i*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        pipe_d  = pipe_q;
        ld_go   = 1'b0;
        step_go = 1'b0;
        if (en) begin
            if (!adv_ld_n) begin
                if (sel_ok) begin
                    pipe_d.s1_op   = rd_wr_n ? OP_RD : OP_WR;
                    pipe_d.s1_addr = addr;
                    ld_go          = 1'b1;
                end else begin
                    pipe_d.s1_op = OP_NONE;
                end
            end else if (zz) begin
                pipe_d.s1_op = OP_NONE;
            end else if (pipe_q.s1_op != OP_NONE) begin
                pipe_d.s1_addr = {pipe_q.s1_addr[ADDR_W-1 -: HW], nxt_lo};
                step_go        = 1'b1;
            end
            pipe_d.s1_lane = ~be_n;
            pipe_d.s2_op   = pipe_q.s1_op;
            pipe_d.s2_addr = pipe_q.s1_addr;
            pipe_d.s2_lane = pipe_q.s1_lane;
            pipe_d.wb_vld  = 1'b0;
            case (pipe_q.s2_op)
                OP_RD: begin
                    pipe_d.dout  = rd_merged;
                    pipe_d.drive = 1'b1;
                end
                OP_WR: begin
                    pipe_d.wb_vld  = 1'b1;
                    pipe_d.wb_addr = pipe_q.s2_addr;
                    pipe_d.wb_lane = pipe_q.s2_lane;
                    pipe_d.wb_data = dq_in;
                    pipe_d.drive   = 1'b0;
                end
                default: pipe_d.drive = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dq_out = pipe_q.dout;
    assign dq_oe  = pipe_q.drive && !oe_n;

    // Edges seen since reset release, saturating; bounds the look-back of the checks below.
    logic [2:0] boot_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               boot_q <= '0;
        else if (boot_q != 3'd7)  boot_q <= boot_q + 3'd1;
    end

    logic raw_sel;
    assign raw_sel = !cs0_n && cs1 && !cs2_n;

    assert_oe_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dq_out) && $stable(pipe_q.drive)));

    assert_read_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q >= 3'd3 && !oe_n && !$past(cke_n, 1) && !$past(cke_n, 2) && !$past(cke_n, 3)
         && !$past(adv_ld_n, 3) && $past(raw_sel, 3) && !$past(zz, 3) && $past(rd_wr_n, 3))
        |-> dq_oe);

    assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q >= 3'd3 && !$past(cke_n, 1) && !$past(cke_n, 2) && !$past(cke_n, 3)
         && !$past(adv_ld_n, 3) && !$past(raw_sel, 3))
        |-> !dq_oe);

    assert_zz_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q >= 3'd3 && !$past(cke_n, 1) && !$past(cke_n, 2) && !$past(cke_n, 3)
         && !$past(adv_ld_n, 3) && $past(zz, 3))
        |-> !dq_oe);

    assert_dummy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q >= 3'd4 && !$past(cke_n, 1) && !$past(cke_n, 2) && !$past(cke_n, 3)
         && !$past(cke_n, 4) && !$past(adv_ld_n, 4) && !$past(raw_sel, 4)
         && $past(adv_ld_n, 3))
        |-> !dq_oe);
endmodule

// File: tb/tb_sram_ntd_pipe.sv
`timescale 1ns/1ps
module tb_sram_ntd_pipe;
    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0, zz = 1'b0, adv_ld_n = 1'b0, rd_wr_n = 1'b1;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic          lin_burst = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sram_ntd_pipe #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .zz(zz), .adv_ld_n(adv_ld_n),
        .rd_wr_n(rd_wr_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .be_n(be_n),
        .lin_burst(lin_burst), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ld_n, rd, sel (all three selects good), be_n, lin, addr, din, exp_oe, exp_q, tag
    typedef struct packed {
        logic        ld_n;
        logic        rd;
        logic        sel;
        logic [3:0]  be_n;
        logic        lin;
        logic [9:0]  a;
        logic [31:0] din;
        logic        exp_oe;
        logic [31:0] exp_q;
        logic [2:0]  tag;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,4'h0,1'b0,10'h010,32'h00000000,1'b0,32'h0,3'd0},         // W 010, reset state R1
        '{1'b0,1'b0,1'b1,4'h0,1'b0,10'h011,32'h00000000,1'b0,32'h0,3'd0},         // W 011
        '{1'b0,1'b1,1'b1,4'h0,1'b0,10'h010,32'h11111111,1'b0,32'h0,3'd0},         // R 010, data for W 010
        '{1'b0,1'b1,1'b1,4'h0,1'b0,10'h011,32'h22222222,1'b0,32'h0,3'd1},         // R 011, data for W 011 (R2)
        '{1'b0,1'b0,1'b1,4'hE,1'b0,10'h010,32'h00000000,1'b0,32'h0,3'd1},         // W 010 lane 0 only (R3)
        '{1'b0,1'b1,1'b1,4'h0,1'b0,10'h010,32'h00000000,1'b1,32'h11111111,3'd0},  // R 010 behind write (R4)
        '{1'b0,1'b0,1'b0,4'h0,1'b0,10'h000,32'h000000AB,1'b1,32'h22222222,3'd0},  // deselect
        '{1'b1,1'b1,1'b1,4'h0,1'b0,10'h000,32'h00000000,1'b0,32'h0,3'd1},         // dummy continue (R8)
        '{1'b0,1'b0,1'b1,4'h0,1'b1,10'h022,32'h00000000,1'b1,32'h111111AB,3'd3},  // W burst 022 linear; R4 merge
        '{1'b1,1'b1,1'b1,4'h0,1'b1,10'h000,32'h00000000,1'b0,32'h0,3'd6},         // continue, rd ignored; R7 quiet
        '{1'b1,1'b0,1'b1,4'h0,1'b1,10'h000,32'hA0A0A0A0,1'b0,32'h0,3'd7},         // R8 dummy drove nothing
        '{1'b1,1'b0,1'b1,4'h0,1'b1,10'h000,32'hA1A1A1A1,1'b0,32'h0,3'd1},
        '{1'b0,1'b1,1'b1,4'h0,1'b0,10'h021,32'hA2A2A2A2,1'b0,32'h0,3'd4},         // R burst 021 interleaved
        '{1'b1,1'b0,1'b1,4'h0,1'b0,10'h000,32'hA3A3A3A3,1'b0,32'h0,3'd1},         // continue, rd ignored (R5)
        '{1'b1,1'b1,1'b1,4'h0,1'b0,10'h000,32'h00000000,1'b0,32'h0,3'd1},
        '{1'b1,1'b1,1'b1,4'h0,1'b0,10'h000,32'h00000000,1'b1,32'hA3A3A3A3,3'd3},  // 021 via buffer (R4)
        '{1'b0,1'b1,1'b0,4'h0,1'b0,10'h000,32'h00000000,1'b1,32'hA2A2A2A2,3'd5},  // 020 (R6 interleave)
        '{1'b0,1'b1,1'b0,4'h0,1'b0,10'h000,32'h00000000,1'b1,32'hA1A1A1A1,3'd4},  // 023 (R5)
        '{1'b0,1'b1,1'b0,4'h0,1'b0,10'h000,32'h00000000,1'b1,32'hA0A0A0A0,3'd5},  // 022 (R6 linear)
        '{1'b0,1'b1,1'b0,4'h0,1'b0,10'h000,32'h00000000,1'b0,32'h0,3'd6}          // R7 quiet
    };

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic issue(input logic ck_n, input logic zzi, input logic ld_n, input logic rd,
                         input logic c0n, input logic c1, input logic c2n, input logic [3:0] ben,
                         input logic lin, input logic [9:0] a, input logic [31:0] d);
        cke_n = ck_n; zz = zzi; adv_ld_n = ld_n; rd_wr_n = rd;
        cs0_n = c0n; cs1 = c1; cs2_n = c2n; be_n = ben; lin_burst = lin; addr = a; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [31:0] d);
        issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 10'h000, d);
    endtask

    task automatic rd_word(input logic [9:0] a);
        issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, a, 32'h0);
        idle(32'h0);
        idle(32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R12 drive in reset", {31'b0, dq_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R12 drive after reset", {31'b0, dq_oe}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            chk(dq_oe == VEC[i].exp_oe, tag_name(VEC[i].tag), {31'b0, dq_oe}, {31'b0, VEC[i].exp_oe});
            if (VEC[i].exp_oe)
                chk(dq_out == VEC[i].exp_q, tag_name(VEC[i].tag), dq_out, VEC[i].exp_q);
            issue(1'b0, 1'b0, VEC[i].ld_n, VEC[i].rd, !VEC[i].sel, VEC[i].sel, !VEC[i].sel,
                  VEC[i].be_n, VEC[i].lin, VEC[i].a, VEC[i].din);
        end

        // R1 plus R10: output enable acts without a clock edge
        rd_word(10'h020);
        chk(dq_oe && dq_out == 32'hA2A2A2A2, "R1 read 020", dq_out, 32'hA2A2A2A2);
        oe_n = 1'b1;
        #1;
        chk(dq_oe == 1'b0, "R10 oe_n high", {31'b0, dq_oe}, 32'h0);
        oe_n = 1'b0;
        #1;
        chk(dq_oe == 1'b1, "R10 oe_n low", {31'b0, dq_oe}, 32'h1);

        // R9: frozen edges change nothing, then the read completes
        issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 10'h022, 32'h0);
        idle(32'h0);
        for (int k = 0; k < 3; k++)
            issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 10'h023, 32'hFFFFFFFF);
        chk(dq_oe == 1'b0 && dq_out == 32'hA2A2A2A2, "R9 held during freeze", dq_out, 32'hA2A2A2A2);
        idle(32'h0);
        chk(dq_oe && dq_out == 32'hA0A0A0A0, "R9 read resumes", dq_out, 32'hA0A0A0A0);
        rd_word(10'h023);
        chk(dq_out == 32'hA1A1A1A1, "R9 no write while frozen", dq_out, 32'hA1A1A1A1);

        // R7: one select wrong, write refused
        issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 10'h020, 32'h0);
        idle(32'h0);
        idle(32'hDEADBEEF);
        chk(dq_oe == 1'b0, "R7 deselect drives nothing", {31'b0, dq_oe}, 32'h0);
        rd_word(10'h020);
        chk(dq_out == 32'hA2A2A2A2, "R7 deselected write ignored", dq_out, 32'hA2A2A2A2);

        // R11: snooze refuses a write
        issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 10'h021, 32'h0);
        idle(32'h0);
        idle(32'h55555555);
        rd_word(10'h021);
        chk(dq_out == 32'hA3A3A3A3, "R11 snooze write ignored", dq_out, 32'hA3A3A3A3);

        // R3: all lanes off, then top lane only
        issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 10'h023, 32'h0);
        idle(32'h0);
        idle(32'hFFFFFFFF);
        rd_word(10'h023);
        chk(dq_out == 32'hA1A1A1A1, "R3 no lane enabled", dq_out, 32'hA1A1A1A1);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h7, 1'b0, 10'h022, 32'h0);
        idle(32'h0);
        idle(32'h5A000000);
        rd_word(10'h022);
        chk(dq_out == 32'h5AA0A0A0, "R3 lane 3 only", dq_out, 32'h5AA0A0A0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule